// File: doc/BRIEF.md
# Fall-Through Elastic FIFO

This block is a first-in first-out buffer of sixteen 4-bit words with no read or write pointers. Every storage stage keeps a word and an occupancy marker. On each clock, any occupied stage whose successor is vacant hands its word forward and becomes vacant. Words therefore drift toward the output end and vacancies drift back toward the input end. The time a word spends in transit depends on how far it has to fall.

A producer presents a word and raises a shift-in strobe while the input-ready flag is high. A consumer reads the word presented at the output whenever the output-ready flag is high. It then removes that word with a falling edge on a shift-out strobe. A master clear empties the buffer by clearing only the markers; the stored words keep their values. An output-disable input floats the data outputs without affecting removal. Both strobes are level inputs sampled in one system clock, and the block detects their edges internally.

Top module: `ripple_fifo`

## Requirements
- R1: While `masterClr` is high at a clock edge, every marker is cleared: after that edge `inReady` is 1 and `outReady` is 0.
- R2: Master clear does not change stored data: `dataOut` shows the same word before and after a clear.
- R3: A word loaded into an empty buffer reaches the output after exactly 16 clock edges, counting the loading edge. `outReady` is 0 after 15 edges and 1 after 16, and `dataOut` then equals the loaded word.
- R4: Words leave in the order they were accepted, with none lost and none duplicated.
- R5: Only a 0-to-1 transition of `shiftIn` loads a word. Holding `shiftIn` high for many cycles loads exactly one word.
- R6: Once 16 words are stored and have settled, `inReady` is 0. Further rising edges of `shiftIn` are ignored, and their data never appears at the output.
- R7: `inReady` is 0 right after the edge that loads a word. It returns to 1 after the next edge if the second stage was vacant.
- R8: A 1-to-0 transition of `shiftOut` while `outReady` is 1 clears `outReady` at the edge that samples it. If the stage before the last is occupied, `outReady` is 1 again one edge later.
- R9: A falling edge of `shiftOut` while `outReady` is 0 has no effect: the flags do not change and a later word still passes through intact.
- R10: If `shiftIn` is high while `masterClr` is released, `dataIn` is loaded at the first edge after release.
- R11: When `outDisable` is 1, all bits of `dataOut` are high impedance. Removal through `shiftOut` works the same whether `outDisable` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| masterClr | input | 1 | Synchronous active-high clear of all markers |
| shiftIn | input | 1 | Load strobe; a rising edge loads `dataIn` |
| dataIn | input | 4 | Word to be loaded |
| inReady | output | 1 | High when the first stage is vacant |
| shiftOut | input | 1 | Removal strobe; a falling edge removes the output word |
| outReady | output | 1 | High when the last stage holds a word |
| outDisable | input | 1 | High floats `dataOut` |
| dataOut | output | 4 | Word held in the last stage, or high impedance |

## Verification
A corrupted marker chain shows up at the ports quickly. A marker set without a word behind it appears as an extra word or a duplicated word at the output. A marker lost in transit appears as a missing word. Either fault becomes visible within about 16 clocks, as soon as the affected position falls to the output. A wrong forwarding rule also shifts the fall-through delay of a single word away from exactly 16 edges, and a wrong full-detection rule lets a seventeenth word overwrite one in flight. The bench therefore compares the exact delay, the drained sequence against a reference queue, and the flags right after each strobe edge.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  localparam int unsigned DEF_WORD_W = 4;
  localparam int unsigned DEF_DEPTH  = 16;

  // Strobes from the control to the stage chain, each valid for one clock.
  typedef struct packed {
    logic loadFirst;   // write the input word into the first stage
    logic popLast;     // vacate the last stage
  } stageCmd_t;
endpackage

// File: rtl/ripple_fifo_ctrl.sv
module ripple_fifo_ctrl
  import ripple_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      shiftIn,
  input  logic      shiftOut,
  input  logic      firstFull,
  input  logic      lastFull,
  output stageCmd_t cmd
);
  logic inPrev;
  logic outPrev;
  logic inRise;
  logic outFall;

  // Registered copies of the strobes. They are held at 0 during clear, so a
  // high shiftIn at release counts as a fresh rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      inPrev  <= 1'b0;
      outPrev <= 1'b0;
    end else begin
      inPrev  <= shiftIn;
      outPrev <= shiftOut;
    end
  end

  assign inRise  = shiftIn & ~inPrev;
  assign outFall = outPrev & ~shiftOut;

  always_comb begin
    cmd.loadFirst = inRise & ~firstFull;
    cmd.popLast   = outFall & lastFull;
  end

  // R5: a level held high cannot produce two loads in a row
  assert_single_load_R5: assert property (@(posedge clk) disable iff (rst)
    cmd.loadFirst |=> !cmd.loadFirst);
endmodule

// File: rtl/ripple_fifo_stages.sv
module ripple_fifo_stages
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  stageCmd_t         cmd,
  input  logic [WORD_W-1:0] dataIn,
  output logic              firstFull,
  output logic              lastFull,
  output logic [WORD_W-1:0] lastWord
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0]  mark;
  logic [DEPTH-1:0]  fill;    // stage receives a word this clock
  logic [DEPTH-1:0]  drain;   // stage hands its word on this clock
  logic [DEPTH-1:0]  markNext;
  logic [WORD_W-1:0] word    [DEPTH];
  logic [WORD_W-1:0] srcWord [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign fill[i]    = cmd.loadFirst & ~mark[i];
      assign srcWord[i] = dataIn;
    end else begin : g_body
      assign fill[i]    = mark[i-1] & ~mark[i];
      assign srcWord[i] = word[i-1];
    end
    if (i == LAST) begin : g_tail
      assign drain[i] = cmd.popLast & mark[i];
    end else begin : g_link
      assign drain[i] = fill[i+1];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      markNext[i] = fill[i] | (mark[i] & ~drain[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mark <= '0;
    else     mark <= markNext;
  end

  // Data words are never reset; clear only invalidates them via the markers.
  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill[i]) word[i] <= srcWord[i];
      end
    end
  end

  assign firstFull = mark[0];
  assign lastFull  = mark[LAST];
  assign lastWord  = word[LAST];

  // R1: clear empties every stage
  assert_clear_empties_R1: assert property (@(posedge clk)
    rst |=> (mark == '0));

  // R4: occupancy changes only by accepted loads and removals
  assert_count_conserved_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(mark) ==
      $countones($past(mark)) + int'($past(cmd.loadFirst)) - int'($past(cmd.popLast))));

  // R6: a load never lands on an occupied first stage
  assert_no_load_full_R6: assert property (@(posedge clk) disable iff (rst)
    cmd.loadFirst |-> !mark[0]);

  // R9: a removal never hits an empty last stage
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
    cmd.popLast |-> mark[LAST]);

  // R8: removal vacates the last stage at that edge
  assert_pop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    cmd.popLast |=> !mark[LAST]);
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              masterClr,
  input  logic              shiftIn,
  input  logic [WORD_W-1:0] dataIn,
  output logic              inReady,
  input  logic              shiftOut,
  output logic              outReady,
  input  logic              outDisable,
  output logic [WORD_W-1:0] dataOut
);
  stageCmd_t         cmd;
  logic              firstFull;
  logic              lastFull;
  logic [WORD_W-1:0] lastWord;

  ripple_fifo_ctrl u_ctrl (
    .clk       (clk),
    .rst       (masterClr),
    .shiftIn   (shiftIn),
    .shiftOut  (shiftOut),
    .firstFull (firstFull),
    .lastFull  (lastFull),
    .cmd       (cmd)
  );

  ripple_fifo_stages #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_stages (
    .clk       (clk),
    .rst       (masterClr),
    .cmd       (cmd),
    .dataIn    (dataIn),
    .firstFull (firstFull),
    .lastFull  (lastFull),
    .lastWord  (lastWord)
  );

  assign inReady  = ~firstFull;
  assign outReady = lastFull;
  assign dataOut  = outDisable ? {WORD_W{1'bz}} : lastWord;
endmodule

// File: tb/sim_ripple_fifo.sv
`timescale 1ns/1ps
module sim_ripple_fifo;
  logic       clk = 1'b0;
  logic       masterClr = 1'b1;
  logic       shiftIn = 1'b0;
  logic [3:0] dataIn = 4'h0;
  logic       inReady;
  logic       shiftOut = 1'b0;
  logic       outReady;
  logic       outDisable = 1'b0;
  logic [3:0] dataOut;

  int total = 0;
  int failed = 0;
  logic [3:0] model[$];

  always #10 clk = ~clk;   // 50 MHz

  ripple_fifo u0 (
    .clk(clk), .masterClr(masterClr), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outReady(outReady),
    .outDisable(outDisable), .dataOut(dataOut)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clearAll(logic holdIn);
    masterClr = 1'b1; shiftIn = holdIn;
    tick(2);
    masterClr = 1'b0;
  endtask

  task automatic pushWord(logic [3:0] w, bit expectAccept);
    if (expectAccept) begin
      for (int k = 0; k < 40 && !inReady; k++) tick();
      model.push_back(w);
    end
    dataIn = w; shiftIn = 1'b1;
    tick();
    shiftIn = 1'b0;
    tick();
  endtask

  task automatic popWord(bit checkRefill);
    logic [3:0] exp;
    for (int k = 0; k < 40 && !outReady; k++) tick();
    exp = model.pop_front();
    check("R4 word order", dataOut, exp);
    shiftOut = 1'b1; tick();
    shiftOut = 1'b0; tick();
    check("R8 outReady cleared by removal", {3'b0, outReady}, 4'h0);
    if (checkRefill) begin
      tick();
      check("R8 refill one edge later", {3'b0, outReady}, {3'b0, model.size() > 0});
    end
  endtask

  task automatic testClear();
    tick(3);
    check("R1 inReady after clear", {3'b0, inReady}, 4'h1);
    check("R1 outReady after clear", {3'b0, outReady}, 4'h0);
  endtask

  task automatic testLatency();
    pushWord(4'hA, 1'b1);   // load edge is the first of these two ticks
    tick(13);               // 15 edges since the load edge
    check("R3 not yet at output after 15 edges", {3'b0, outReady}, 4'h0);
    tick();
    check("R3 at output after 16 edges", {3'b0, outReady}, 4'h1);
    check("R3 word at output", dataOut, 4'hA);
    popWord(1'b0);
  endtask

  task automatic testInReadyPulse();
    dataIn = 4'h2; shiftIn = 1'b1; model.push_back(4'h2);
    tick();
    check("R7 inReady low after load", {3'b0, inReady}, 4'h0);
    shiftIn = 1'b0;
    tick();
    check("R7 inReady back high", {3'b0, inReady}, 4'h1);
    tick(20);
    popWord(1'b0);
  endtask

  task automatic testHold();
    dataIn = 4'h5; shiftIn = 1'b1;
    tick(30);
    shiftIn = 1'b0;
    tick(20);
    model.push_back(4'h5);
    check("R5 one word present", {3'b0, outReady}, 4'h1);
    popWord(1'b0);
    tick(20);
    check("R5 no second word", {3'b0, outReady}, 4'h0);
  endtask

  task automatic testEmptyPop();
    for (int k = 0; k < 3; k++) begin
      shiftOut = 1'b1; tick(); shiftOut = 1'b0; tick();
    end
    check("R9 outReady stays low", {3'b0, outReady}, 4'h0);
    check("R9 inReady stays high", {3'b0, inReady}, 4'h1);
    pushWord(4'h7, 1'b1);
    tick(20);
    popWord(1'b0);
    tick(20);
    check("R9 buffer empty again", {3'b0, outReady}, 4'h0);
  endtask

  task automatic testFill();
    for (int k = 0; k < 16; k++) pushWord(4'((k * 3 + 1) & 15), 1'b1);
    tick(20);
    check("R6 inReady low when full", {3'b0, inReady}, 4'h0);
    pushWord(4'hE, 1'b0);
    pushWord(4'hD, 1'b0);
    tick(5);
    check("R6 still full", {3'b0, inReady}, 4'h0);
    for (int k = 0; k < 16; k++) popWord(1'b1);
    tick(20);
    check("R6 ignored words never appear", {3'b0, outReady}, 4'h0);
    check("R4 all words drained", 4'(model.size()), 4'h0);
  endtask

  task automatic testClearKeepsData();
    pushWord(4'h9, 1'b1);
    pushWord(4'h6, 1'b1);
    tick(20);
    check("R2 word before clear", dataOut, 4'h9);
    clearAll(1'b0);
    model.delete();
    tick();
    check("R1 outReady low after clear", {3'b0, outReady}, 4'h0);
    check("R1 inReady high after clear", {3'b0, inReady}, 4'h1);
    check("R2 data kept through clear", dataOut, 4'h9);
    tick(20);
    check("R1 no word reappears", {3'b0, outReady}, 4'h0);
  endtask

  task automatic testClearLoad();
    dataIn = 4'hC;
    clearAll(1'b1);
    tick();
    check("R10 load at first edge after release", {3'b0, inReady}, 4'h0);
    shiftIn = 1'b0;
    model.push_back(4'hC);
    tick(20);
    popWord(1'b0);
  endtask

  task automatic testOutDisable();
    pushWord(4'h3, 1'b1);
    pushWord(4'h4, 1'b1);
    tick(20);
    outDisable = 1'b1;
    tick();
    check("R11 outputs float", dataOut, 4'bzzzz);
    check("R11 outReady with outputs off", {3'b0, outReady}, 4'h1);
    shiftOut = 1'b1; tick(); shiftOut = 1'b0; tick();
    check("R11 removal while disabled", {3'b0, outReady}, 4'h0);
    void'(model.pop_front());
    tick(3);
    outDisable = 1'b0;
    tick();
    popWord(1'b0);
  endtask

  initial begin
    #(20 * 150000);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    tick(2);
    masterClr = 1'b0;
    testClear();
    testLatency();
    testInReadyPulse();
    testHold();
    testEmptyPop();
    testFill();
    testClearKeepsData();
    testClearLoad();
    testOutDisable();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule